// File: doc/BRIEF.md
# Serial Byte-Pair Receiver with Residual Recovery

This block takes bytes from a synchronous serial link and stores them two at a time as 16-bit entries in a small receive FIFO. A one-bit-period sync marker announces each byte, and the byte then follows, most significant bit first. Back-to-back bytes form one transmission. A transmission ends when the bit period after a byte's last bit carries no sync.

Because entries are only written in pairs, a transmission with an odd byte count leaves one byte behind. The receiver keeps that byte and raises two flags, valid and framed. Software can push the held byte into the FIFO by pulsing a pop strobe, then read the flags back to learn whether the pushed entry is good. If a new transmission began before the pop, the flags show it. The held byte is not lost in that case: it becomes the upper byte of the next stored pair.

Top module: `resid_ser_rx`

## Requirements
- R1: On each `bit_tick`, `ser_sync` and `ser_data` are sampled. A byte begins with a tick where `ser_sync`=1 and is followed by 8 ticks carrying the bits MSB first. A tick with `ser_sync`=1 right after the last bit starts the next byte of the same transmission.
- R2: Bytes are paired in arrival order. The earlier byte fills bits [15:8] and the later byte fills bits [7:0] of one FIFO entry, and no entry is written for a lone byte.
- R3: If the tick after a byte's last bit has `ser_sync`=0, the transmission ends. If one byte is still unpaired at that point, both `res_valid` and `res_framed` go to 1.
- R4: A sync tick while no transmission is in progress starts a new transmission and clears both `res_valid` and `res_framed`.
- R5: A `pop_wr` pulse while `res_valid`=1 writes the entry {8'h00, held byte} to the FIFO in the following cycle and clears `res_valid`. `res_framed` stays 1, so the flags read back as valid=0, framed=1.
- R6: A `pop_wr` pulse while `res_valid`=0 still writes {8'h00, held byte} but changes no flag and keeps the held byte. After a race with a new transmission, the flags therefore read back as valid=0, framed=0.
- R7: A held byte that has not been consumed by a pop becomes bits [15:8] of the entry formed with the first byte of the next transmission.
- R8: The FIFO shows its oldest entry on `rd_data` while `rx_empty`=0. A cycle with `rd_en`=1 removes that entry. `rx_full` is 1 when DEPTH entries are held.
- R9: A write that arrives while the FIFO is full is dropped and sets `rx_overrun`, which stays 1 until reset.
- R10: After reset, `rx_empty`=1, `rx_full`=0, and `res_valid`, `res_framed` and `rx_overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| ser_sync | input | 1 | Frame sync, sampled on bit_tick |
| ser_data | input | 1 | Serial data, sampled on bit_tick |
| pop_wr | input | 1 | Software strobe pushing the held byte |
| rd_en | input | 1 | Removes the FIFO head entry |
| rd_data | output | 16 | FIFO head entry |
| rx_empty | output | 1 | FIFO holds no entry |
| rx_full | output | 1 | FIFO holds DEPTH entries |
| res_valid | output | 1 | Held byte is available to pop |
| res_framed | output | 1 | Held byte belongs to the last finished transmission |
| rx_overrun | output | 1 | Sticky: a write was dropped on a full FIFO |

## Verification
The assertions check several properties on every cycle. The valid flag is never set without the framed flag. The framed flag rises only after an end-of-transmission tick. The valid flag falls only after a transmission start or a pop. A write to a full FIFO always leaves the overrun flag set, and the FIFO never reports full and empty at the same time. Other behaviours can only be shown by the bench's scenarios: the byte order inside each entry, the value of a popped entry, and the carry of a held byte into the next pair after a pop that raced a new transmission.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HWORD_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [HWORD_W-1:0] hword_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxr_deser.sv
module rxr_deser
  import rxr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_tick,
  input  logic  ser_sync,
  input  logic  ser_data,
  output logic  start_evt,
  output logic  byte_done,
  output byte_t byte_val,
  output logic  end_evt
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  rx_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  byte_t            shreg_q, shreg_n;

  // event decode from current state and sampled pins
  assign start_evt = bit_tick && (state_q == ST_IDLE) && ser_sync;
  assign byte_done = bit_tick && (state_q == ST_SHIFT) && (cnt_q == LAST_BIT);
  assign byte_val  = {shreg_q[BYTE_W-2:0], ser_data};
  assign end_evt   = bit_tick && (state_q == ST_GAP) && !ser_sync;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shreg_n = shreg_q;
    if (bit_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (ser_sync) begin
            state_n = ST_SHIFT;
            cnt_n   = '0;
          end
        end
        ST_SHIFT: begin
          shreg_n = {shreg_q[BYTE_W-2:0], ser_data};
          cnt_n   = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_n = ST_GAP;
        end
        ST_GAP: begin
          cnt_n   = '0;
          state_n = ser_sync ? ST_SHIFT : ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (bit_tick) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      shreg_q <= shreg_n;
    end
  end

  // R1
  gap_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (state_q == ST_GAP));
endmodule

// File: rtl/rxr_fifo.sv
module rxr_fifo
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  hword_t wr_data,
  input  logic   rd_en,
  output hword_t rd_data,
  output logic   empty,
  output logic   full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  hword_t         mem_q [DEPTH];
  logic [AW-1:0]  wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           do_wr, do_rd;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem_q[rptr_q];

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (do_wr) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_rd) rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_wr && !do_rd) cnt_n = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wptr_q == AW'(i))) mem_q[i] <= wr_data;
    end
  end

  // R8
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> full);
endmodule

// File: rtl/rxr_resid_ctl.sv
module rxr_resid_ctl
  import rxr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_evt,
  input  logic   byte_done,
  input  byte_t  byte_val,
  input  logic   end_evt,
  input  logic   pop_wr,
  input  logic   fifo_full,
  output logic   wr_en,
  output hword_t wr_data,
  output logic   res_valid,
  output logic   res_framed,
  output logic   rx_overrun
);
  byte_t hold_q, hold_n;
  logic  hvld_q, hvld_n;
  logic  val_q, val_n, frm_q, frm_n;
  logic  preq_q, preq_n;
  byte_t pdat_q, pdat_n;
  logic  ovr_q, ovr_n;
  logic  pair_wr;

  assign pair_wr = byte_done && hvld_q;
  assign wr_en   = pair_wr || preq_q;
  assign wr_data = pair_wr ? {hold_q, byte_val} : {{BYTE_W{1'b0}}, pdat_q};

  always_comb begin
    hold_n = hold_q;
    hvld_n = hvld_q;
    val_n  = val_q;
    frm_n  = frm_q;
    preq_n = preq_q;
    pdat_n = pdat_q;
    ovr_n  = ovr_q | (wr_en && fifo_full);

    // pairing: second byte completes an entry
    if (byte_done) begin
      if (hvld_q) begin
        hvld_n = 1'b0;
      end else begin
        hold_n = byte_val;
        hvld_n = 1'b1;
      end
    end

    if (end_evt && hvld_q) begin
      val_n = 1'b1;
      frm_n = 1'b1;
    end
    if (start_evt) begin
      val_n = 1'b0;
      frm_n = 1'b0;
    end

    // pending pop entry yields to a pair write
    if (preq_q && !pair_wr) preq_n = 1'b0;
    if (pop_wr) begin
      preq_n = 1'b1;
      pdat_n = hold_q;
      if (val_q && !start_evt) begin
        val_n  = 1'b0;
        hvld_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hvld_q <= 1'b0;
      val_q  <= 1'b0;
      frm_q  <= 1'b0;
      preq_q <= 1'b0;
      pdat_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_n;
      hvld_q <= hvld_n;
      val_q  <= val_n;
      frm_q  <= frm_n;
      preq_q <= preq_n;
      pdat_q <= pdat_n;
      ovr_q  <= ovr_n;
    end
  end

  assign res_valid  = val_q;
  assign res_framed = frm_q;
  assign rx_overrun = ovr_q;

  // R5
  valid_needs_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_framed);

  // R3
  framed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_framed) |-> $past(end_evt));

  // R4
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(start_evt || pop_wr));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> rx_overrun);
endmodule

// File: rtl/resid_ser_rx.sv
module resid_ser_rx
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        ser_sync,
  input  logic        ser_data,
  input  logic        pop_wr,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        res_valid,
  output logic        res_framed,
  output logic        rx_overrun
);
  logic   start_evt, byte_done, end_evt, wr_en;
  byte_t  byte_val;
  hword_t wr_data, fifo_out;

  rxr_deser u_deser (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ser_sync(ser_sync),
    .ser_data(ser_data), .start_evt(start_evt), .byte_done(byte_done),
    .byte_val(byte_val), .end_evt(end_evt)
  );

  rxr_resid_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .byte_done(byte_done),
    .byte_val(byte_val), .end_evt(end_evt), .pop_wr(pop_wr),
    .fifo_full(rx_full), .wr_en(wr_en), .wr_data(wr_data),
    .res_valid(res_valid), .res_framed(res_framed), .rx_overrun(rx_overrun)
  );

  rxr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(fifo_out), .empty(rx_empty), .full(rx_full)
  );

  assign rd_data = fifo_out;
endmodule

// File: tb/resid_ser_rx_bench.sv
module resid_ser_rx_bench;
  localparam int DEPTH = 8;

  logic        clk, rst_n, bit_tick, ser_sync, ser_data, pop_wr, rd_en;
  logic [15:0] rd_data;
  logic        rx_empty, rx_full, res_valid, res_framed, rx_overrun;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 0;
  bit done   = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  resid_ser_rx #(.DEPTH(DEPTH)) u_resid_ser_rx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ser_sync(ser_sync),
    .ser_data(ser_data), .pop_wr(pop_wr), .rd_en(rd_en), .rd_data(rd_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .res_valid(res_valid),
    .res_framed(res_framed), .rx_overrun(rx_overrun)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_word(input logic [15:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input logic s, input logic d);
    @(negedge clk); bit_tick = 1; ser_sync = s; ser_data = d;
    @(negedge clk); bit_tick = 0; ser_sync = 0; ser_data = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); pop_wr = 1;
    @(negedge clk); pop_wr = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit pop_mid);
    tick(1'b1, 1'b0);
    if (pop_mid) pop();
    for (int i = 7; i >= 0; i--) tick(1'b0, b[i]);
  endtask

  task automatic end_frame();
    tick(1'b0, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_flags(input logic v, input logic f, input string tag);
    check(tag, {14'd0, res_valid, res_framed}, {14'd0, v, f});
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 queue drained", 16'(exp_q.size()), 16'd0);
    check("R8 empty after drain", {15'd0, rx_empty}, 16'd1);
  endtask

  // monitor: pops the FIFO and compares with the scoreboard
  initial begin
    rd_en = 0;
    forever begin
      @(negedge clk);
      rd_en = 0;
      if (mon_en && rst_n && !rx_empty) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected entry", rd_data, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
        rd_en = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bit_tick = 0; ser_sync = 0; ser_data = 0; pop_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 empty", {15'd0, rx_empty}, 16'd1);
    check("R10 full", {15'd0, rx_full}, 16'd0);
    check_flags(1'b0, 1'b0, "R10 flags");
    check("R10 overrun", {15'd0, rx_overrun}, 16'd0);
    mon_en = 1;

    // R1 R2: two bytes, one entry
    expect_word(16'hA1B2, "R2 pair A1B2");
    send_byte(8'hA1, 0); send_byte(8'hB2, 0); end_frame();
    check_flags(1'b0, 1'b0, "R3 even frame leaves flags clear");

    // R1 R2: four bytes, back to back
    expect_word(16'h0F5A, "R1 pair 0F5A");
    expect_word(16'hC381, "R1 pair C381");
    send_byte(8'h0F, 0); send_byte(8'h5A, 0);
    send_byte(8'hC3, 0); send_byte(8'h81, 0); end_frame();
    drain();

    // R3 R5: odd frame, good pop
    expect_word(16'h1122, "R2 pair 1122");
    send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0); end_frame();
    check_flags(1'b1, 1'b1, "R3 residual flags set");
    expect_word(16'h0033, "R5 popped residual");
    pop();
    check_flags(1'b0, 1'b1, "R5 readback after good pop");
    // R4: new frame clears framed; popped byte not reused
    expect_word(16'h4455, "R4 next frame after pop");
    send_byte(8'h44, 0);
    check_flags(1'b0, 1'b0, "R4 start clears flags");
    send_byte(8'h55, 0); end_frame();
    drain();

    // R6: pop races a new transmission
    send_byte(8'h77, 0); end_frame();
    check_flags(1'b1, 1'b1, "R6 residual before race");
    expect_word(16'h0077, "R6 popped entry during race");
    expect_word(16'h7788, "R6 held byte leads next pair");
    send_byte(8'h88, 1);
    check_flags(1'b0, 1'b0, "R6 readback after race");
    send_byte(8'h99, 0); end_frame();
    check_flags(1'b1, 1'b1, "R6 new residual");
    expect_word(16'h0099, "R5 second pop");
    pop();
    check_flags(1'b0, 1'b1, "R5 second readback");
    drain();

    // R7: unpopped residual carried into next transmission
    send_byte(8'hAB, 0); end_frame();
    check_flags(1'b1, 1'b1, "R7 residual held");
    expect_word(16'hABCD, "R7 carried residual");
    send_byte(8'hCD, 0); end_frame();
    check_flags(1'b0, 1'b0, "R7 flags after carry");
    drain();

    // R9: overrun with reads stopped
    mon_en = 0;
    for (int i = 0; i < 2 * (DEPTH + 1); i++) begin
      if (i < 2 * DEPTH && (i % 2) == 1)
        expect_word({8'(i + 15), 8'(i + 16)}, "R9 stored before overrun");
      send_byte(8'(i + 16), 0);
    end
    end_frame();
    check("R8 full", {15'd0, rx_full}, 16'd1);
    check("R9 overrun set", {15'd0, rx_overrun}, 16'd1);
    mon_en = 1;
    drain();
    check("R9 overrun sticky", {15'd0, rx_overrun}, 16'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule